// File: doc/BRIEF.md
# Pulse-Swallow Feedback and Reference Divider

This block holds the digital division logic of an integer-N frequency synthesizer. On the VCO side, a dual-modulus prescaler works with a swallow counter and a main counter. Together they divide the VCO clock by M = 32·B + A. In each output period, the prescaler first runs A cycles at modulus 33 and then B−A cycles at modulus 32. On the crystal side, a separate counter divides the reference clock by R. Each side emits one single-cycle pulse per period, and these pulses drive a phase/frequency detector. The locked VCO then settles at f_crystal·(32·B + A)/R.

The programmed values A, B and R are expected to change rarely. Each side copies them into its counters only at its own reload boundary. As a result, a change in the middle of a period never produces a short or long period. If R is below 2, the reference side uses 2. If B is not greater than A, the feedback side raises a flag for as long as that setting is in force.

Top module: `pll_fb_ref_div`

## Requirements
- R1: With B > A, the time between consecutive fb_pulse assertions is exactly 32·B + A vco_clk cycles. Examples: B=750, A=0 gives 24000, and B=781, A=8 gives 25000.
- R2: With R in 2..255, the time between consecutive ref_pulse assertions is exactly R ref_clk cycles.
- R3: An r_val of 0 or 1 gives a reference period of 2 ref_clk cycles.
- R4: cfg_bad is 1 while the feedback counters run with B ≤ A and 0 while they run with B > A. It changes only at a feedback reload, which is the edge that raises fb_pulse, or at the first load after reset.
- R5: A new a_val/b_val has no effect on the feedback period already in progress. It first governs the period that begins at the next reload.
- R6: A new r_val has no effect on the reference period already in progress. It first governs the period that begins at the next reference reload.
- R7: fb_pulse and ref_pulse are each high for exactly one cycle of their own clock.
- R8: While rst_n is low, fb_pulse, ref_pulse and cfg_bad are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| vco_clk | input | 1 | Divided-down VCO clock domain |
| ref_clk | input | 1 | Crystal reference clock domain |
| rst_n | input | 1 | Active-low asynchronous reset for both domains |
| a_val | input | 5 | Swallow count A (unsigned) |
| b_val | input | 10 | Main count B (unsigned) |
| r_val | input | 8 | Reference divide R (unsigned) |
| fb_pulse | output | 1 | One vco_clk pulse per M cycles |
| ref_pulse | output | 1 | One ref_clk pulse per R cycles |
| cfg_bad | output | 1 | Active feedback setting has B ≤ A |

## Verification
The bench measures pulse-to-pulse distances at both ends of the range. It covers A=0, A=31 next to B=32, and the two large ratios 24000 and 25000. A modulus or terminal-count error would show up as a period that is off by one or by whole prescaler cycles.

It also changes the settings just after a pulse. A design that loaded values immediately, instead of at reload, would give that in-progress period the new length rather than the old one. For R of 0 and 1, a missing clamp would stall or run the reference counter every cycle. The flag is checked both when it rises and when it clears, so a flag that only ever latches would be caught.

// File: rtl/pll_div_pkg.sv
package pll_div_pkg;
    // Prescaler modulus selection: low = 2**PW, high = 2**PW + 1
    typedef enum logic {MOD_LOW = 1'b0, MOD_HIGH = 1'b1} modulus_e;

    localparam int unsigned PRE_LOG2_DEF = 5;
    localparam int unsigned REF_MIN_DIV  = 2;
endpackage

// File: rtl/pll_prescaler.sv
module pll_prescaler
    import pll_div_pkg::*;
#(
    parameter int unsigned PW = PRE_LOG2_DEF
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     restart,
    input  modulus_e modulus,
    output logic     tick
);
    localparam int unsigned CW       = PW + 1;
    localparam logic [CW-1:0] LOW_TOP  = CW'((1 << PW) - 1);
    localparam logic [CW-1:0] HIGH_TOP = CW'(1 << PW);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } pre_state_t;

    pre_state_t st_d, st_q;
    logic [CW-1:0] top;

    always_comb begin
        st_d = st_q;
        top  = (modulus == MOD_HIGH) ? HIGH_TOP : LOW_TOP;
        tick = (st_q.cnt == top) && !restart;
        if (restart || tick) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/pll_swallow_ctrl.sv
module pll_swallow_ctrl
    import pll_div_pkg::*;
#(
    parameter int unsigned AW = 5,
    parameter int unsigned BW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic [AW-1:0] a_in,
    input  logic [BW-1:0] b_in,
    output modulus_e      modulus,
    output logic          load,
    output logic          pulse,
    output logic          bad
);
    typedef struct packed {
        logic [AW-1:0] a_rem;
        logic [BW-1:0] b_rem;
        logic          load;
        logic          pulse;
        logic          bad;
    } sw_state_t;

    sw_state_t st_d, st_q;
    logic      in_bad;

    always_comb begin
        st_d       = st_q;
        st_d.pulse = 1'b0;
        in_bad     = (b_in <= BW'(a_in));
        if (st_q.load) begin
            st_d.a_rem = a_in;
            st_d.b_rem = b_in;
            st_d.bad   = in_bad;
            st_d.load  = 1'b0;
        end else if (tick) begin
            if (st_q.b_rem <= BW'(1)) begin
                // last prescaler cycle of the period: reload and emit
                st_d.a_rem = a_in;
                st_d.b_rem = b_in;
                st_d.bad   = in_bad;
                st_d.pulse = 1'b1;
            end else begin
                st_d.b_rem = st_q.b_rem - BW'(1);
                if (st_q.a_rem != '0) begin
                    st_d.a_rem = st_q.a_rem - AW'(1);
                end
            end
        end
    end

    assign modulus = (st_q.a_rem != '0) ? MOD_HIGH : MOD_LOW;
    assign load    = st_q.load;
    assign pulse   = st_q.pulse;
    assign bad     = st_q.bad;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.load  <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/pll_ref_div.sv
module pll_ref_div
    import pll_div_pkg::*;
#(
    parameter int unsigned RW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [RW-1:0] r_in,
    output logic          pulse
);
    localparam logic [RW-1:0] R_FLOOR = RW'(REF_MIN_DIV);

    typedef struct packed {
        logic [RW-1:0] cnt;
        logic          load;
        logic          pulse;
    } ref_state_t;

    ref_state_t    st_d, st_q;
    logic [RW-1:0] r_eff;

    always_comb begin
        st_d       = st_q;
        st_d.pulse = 1'b0;
        r_eff      = (r_in < R_FLOOR) ? R_FLOOR : r_in;
        if (st_q.load || st_q.cnt <= RW'(1)) begin
            st_d.cnt   = r_eff;
            st_d.pulse = !st_q.load;
            st_d.load  = 1'b0;
        end else begin
            st_d.cnt = st_q.cnt - RW'(1);
        end
    end

    assign pulse = st_q.pulse;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.load <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/pll_fb_ref_div.sv
module pll_fb_ref_div
    import pll_div_pkg::*;
#(
    parameter int unsigned PW = PRE_LOG2_DEF,
    parameter int unsigned AW = 5,
    parameter int unsigned BW = 10,
    parameter int unsigned RW = 8
) (
    input  logic          vco_clk,
    input  logic          ref_clk,
    input  logic          rst_n,
    input  logic [AW-1:0] a_val,
    input  logic [BW-1:0] b_val,
    input  logic [RW-1:0] r_val,
    output logic          fb_pulse,
    output logic          ref_pulse,
    output logic          cfg_bad
);
    modulus_e modulus;
    logic     pre_tick;
    logic     fb_load;

    pll_prescaler #(.PW(PW)) u_pre (
        .clk     (vco_clk),
        .rst_n   (rst_n),
        .restart (fb_load),
        .modulus (modulus),
        .tick    (pre_tick)
    );

    pll_swallow_ctrl #(.AW(AW), .BW(BW)) u_sw (
        .clk     (vco_clk),
        .rst_n   (rst_n),
        .tick    (pre_tick),
        .a_in    (a_val),
        .b_in    (b_val),
        .modulus (modulus),
        .load    (fb_load),
        .pulse   (fb_pulse),
        .bad     (cfg_bad)
    );

    pll_ref_div #(.RW(RW)) u_ref (
        .clk   (ref_clk),
        .rst_n (rst_n),
        .r_in  (r_val),
        .pulse (ref_pulse)
    );
endmodule

// File: rtl/pll_fb_ref_div_chk.sv
module pll_fb_ref_div_chk (
    input logic vco_clk,
    input logic ref_clk,
    input logic rst_n,
    input logic fb_pulse,
    input logic ref_pulse,
    input logic cfg_bad,
    input logic fb_load
);
    p_fb_single_r7: assert property (@(posedge vco_clk) disable iff (!rst_n)
        fb_pulse |=> !fb_pulse);

    p_ref_single_r7: assert property (@(posedge ref_clk) disable iff (!rst_n)
        ref_pulse |=> !ref_pulse);

    p_bad_at_reload_r4: assert property (@(posedge vco_clk) disable iff (!rst_n)
        (cfg_bad != $past(cfg_bad)) |-> (fb_pulse || $past(fb_load)));

    p_reset_quiet_fb_r8: assert property (@(posedge vco_clk)
        !rst_n |-> (!fb_pulse && !cfg_bad));

    p_reset_quiet_ref_r8: assert property (@(posedge ref_clk)
        !rst_n |-> !ref_pulse);
endmodule

bind pll_fb_ref_div pll_fb_ref_div_chk u_chk (
    .vco_clk   (vco_clk),
    .ref_clk   (ref_clk),
    .rst_n     (rst_n),
    .fb_pulse  (fb_pulse),
    .ref_pulse (ref_pulse),
    .cfg_bad   (cfg_bad),
    .fb_load   (fb_load)
);

// File: tb/pll_fb_ref_div_bench.sv
`timescale 1ns/1ps
module pll_fb_ref_div_bench;
    logic       vco_clk = 1'b0;
    logic       ref_clk = 1'b0;
    logic       rst_n   = 1'b0;
    logic [4:0] a_val   = 5'd1;
    logic [9:0] b_val   = 10'd2;
    logic [7:0] r_val   = 8'd5;
    logic       fb_pulse, ref_pulse, cfg_bad;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  fb_done = 1'b0;
    bit  ref_done = 1'b0;

    always #2.5 vco_clk = ~vco_clk;
    always #4   ref_clk = ~ref_clk;

    pll_fb_ref_div u_pll_fb_ref_div (
        .vco_clk   (vco_clk),
        .ref_clk   (ref_clk),
        .rst_n     (rst_n),
        .a_val     (a_val),
        .b_val     (b_val),
        .r_val     (r_val),
        .fb_pulse  (fb_pulse),
        .ref_pulse (ref_pulse),
        .cfg_bad   (cfg_bad)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // ---------------- feedback side helpers ----------------
    task automatic fb_sync();
        @(negedge vco_clk);
        while (!fb_pulse) @(negedge vco_clk);
    endtask

    // Called at the negedge where fb_pulse is high; returns cycles to the next one.
    task automatic fb_count(input string req, output int p);
        p = 0;
        do begin
            @(negedge vco_clk);
            p++;
            if (p == 1) check(!fb_pulse, {req, "/R7 width"}, int'(fb_pulse), 0);
        end while (!fb_pulse);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge vco_clk);
        check(!fb_pulse && !ref_pulse && !cfg_bad, "R8", int'({fb_pulse, ref_pulse, cfg_bad}), 0);
        rst_n = 1'b1;
    endtask

    task automatic t_fb_ratio(input int a, input int b);
        int p;
        fb_sync();
        a_val = 5'(a);
        b_val = 10'(b);
        fb_sync();
        fb_count("R1", p);
        check(p == 32 * b + a, "R1", p, 32 * b + a);
        check(!cfg_bad, "R4 clear", int'(cfg_bad), 0);
    endtask

    // Change right after a pulse: the current period must keep the old ratio.
    task automatic t_fb_boundary(input int a, input int b);
        int p, old_m;
        old_m = 32 * int'(b_val) + int'(a_val);
        fb_sync();
        a_val = 5'(a);
        b_val = 10'(b);
        fb_count("R5", p);
        check(p == old_m, "R5 old period", p, old_m);
        fb_count("R5", p);
        check(p == 32 * b + a, "R5 new period", p, 32 * b + a);
    endtask

    task automatic t_fb_invalid();
        fb_sync();
        a_val = 5'd4;
        b_val = 10'd4;
        check(!cfg_bad, "R4 before reload", int'(cfg_bad), 0);
        fb_sync();
        check(cfg_bad, "R4 set", int'(cfg_bad), 1);
        a_val = 5'd5;
        b_val = 10'd6;
        fb_sync();
        check(!cfg_bad, "R4 cleared", int'(cfg_bad), 0);
    endtask

    // ---------------- reference side helpers ----------------
    task automatic ref_sync();
        @(negedge ref_clk);
        while (!ref_pulse) @(negedge ref_clk);
    endtask

    task automatic ref_count(input string req, output int p);
        p = 0;
        do begin
            @(negedge ref_clk);
            p++;
            if (p == 1) check(!ref_pulse, {req, "/R7 width"}, int'(ref_pulse), 0);
        end while (!ref_pulse);
    endtask

    task automatic t_ref_ratio(input int r, input int exp, input string req);
        int p;
        ref_sync();
        r_val = 8'(r);
        ref_sync();
        ref_count(req, p);
        check(p == exp, req, p, exp);
    endtask

    task automatic t_ref_boundary(input int r);
        int p, old_r;
        old_r = int'(r_val);
        ref_sync();
        r_val = 8'(r);
        ref_count("R6", p);
        check(p == old_r, "R6 old period", p, old_r);
        ref_count("R6", p);
        check(p == r, "R6 new period", p, r);
    endtask

    initial begin
        t_reset();
        t_fb_ratio(1, 2);
        t_fb_ratio(0, 5);
        t_fb_ratio(31, 32);
        t_fb_boundary(2, 3);
        t_fb_invalid();
        t_fb_ratio(0, 750);
        t_fb_boundary(8, 781);
        fb_done = 1'b1;
    end

    initial begin
        wait (rst_n);
        t_ref_ratio(5, 5, "R2");
        t_ref_ratio(255, 255, "R2");
        t_ref_ratio(0, 2, "R3");
        t_ref_ratio(1, 2, "R3");
        t_ref_ratio(2, 2, "R2");
        t_ref_boundary(9);
        ref_done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!(fb_done && ref_done) && cyc < 190000) begin
            @(negedge vco_clk);
            cyc++;
        end
        if (!(fb_done && ref_done)) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected < %0d", cyc, 190000);
        end
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule